// File: doc/BRIEF.md
# Byte-Serial SPI Burst Engine

This engine moves 32-bit words from a transmit queue onto an SPI link and turns what comes back into 32-bit words for a receive queue. Software programs a burst length in bits through a length field. After a start strobe the engine keeps taking words until the transmit queue runs dry. Each word is shifted out one byte at a time, most significant byte first, in SPI mode 0. The serial clock is produced by a fixed divider.

A remaining-length counter spans word boundaries. When a burst is not a whole number of words, the short word comes first. The counter is kept when the queue drains, so a later start continues an unfinished burst. Received bytes build up in an accumulator that is pushed once per word. If the receive queue is full at that moment, the word is dropped and an overflow pulse is raised.

A transfer-complete pulse marks the end of the work. In plain mode it also marks every burst boundary. In chained mode, where the select line is held across bursts, only the final drain of the queue is reported.

Top module: `spi_burst_engine`

## Requirements
- R1: The burst length in bits is the length field plus one, rounded up to a multiple of 8. At a word boundary where the remaining count is zero, the count is reloaded from that length. Otherwise the count carries over between words and between start commands. Each byte sent lowers the count by 8.
- R2: The number of bits taken from a word is the remaining count modulo 32, or 32 when that modulo is zero.
- R3: Each word is taken with one `tx_pop_o` pulse. Its bits are sent as bytes, most significant first, starting with bits [n-1:n-8], where n is the bit count from R2.
- R4: The link runs in mode 0. `sclk_o` idles low. `mosi_o` changes only while `sclk_o` is low. `miso_i` is sampled on each rising edge. Consecutive rising edges within a byte are 2*CLK_HALF clock cycles apart.
- R5: The receive accumulator is cleared at the start of each word. Each received byte is shifted in at the low end. The result appears on `rx_data_o` with a one-cycle `rx_push_o` pulse at the end of the word.
- R6: If `rx_full_i` is high at the end of a word, `ovf_o` pulses for one cycle, no push is made and the word is lost.
- R7: `done_o` pulses once at the end of a word in either of two cases: the transmit queue is then empty, or (when `chain_i` is low) the remaining count has reached zero. When both hold, only one pulse is given.
- R8: When `chain_i` is high, burst ends that leave words in the transmit queue raise no `done_o`.
- R9: A start with the transmit queue empty gives exactly one `done_o` pulse, with no pop and no clock activity.
- R10: After reset the engine is idle, with `sclk_o`, `busy_o`, `done_o`, `ovf_o`, `tx_pop_o` and `rx_push_o` low. `busy_o` is high from the cycle after an accepted start until the last word is finished. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| len_field_i | input | LEN_W | Burst length field (bits minus one) |
| chain_i | input | 1 | Chained-burst mode: hold select, report only the final drain |
| tx_empty_i | input | 1 | Transmit queue empty |
| tx_data_i | input | 32 | Head word of the transmit queue |
| tx_pop_o | output | 1 | Pop strobe to the transmit queue |
| rx_full_i | input | 1 | Receive queue full |
| rx_data_o | output | 32 | Received word |
| rx_push_o | output | 1 | Push strobe to the receive queue |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Engine working |
| done_o | output | 1 | Transfer-complete pulse |
| ovf_o | output | 1 | Receive overflow pulse |

## Verification
Two things can fall on the same word end: a burst boundary and the drain of the transmit queue. In that case exactly one `done_o` pulse must appear. A push and an overflow are also decided at the same word end, and they must exclude each other. The sweep provokes both cases by choosing word counts that end either on a burst boundary or inside a burst, and by giving some runs a one-word receive capacity. Each case is judged by comparing the counted `done_o`, `ovf_o` and `rx_push_o` pulses against totals computed arithmetically from the burst length.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_BYTE_GO,
    ST_BYTE_WAIT,
    ST_WORD_END
  } eng_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == CW'(CLK_HALF - 1));

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] din_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       active_o,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] dout_o,
  output logic       done_o
);
  logic       act_q, act_d;
  logic       sclk_q, sclk_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] rx_q, rx_d;
  logic [2:0] cnt_q, cnt_d;
  logic       done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load_i) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      tx_d   = din_i;
      cnt_d  = 3'd0;
    end else if (act_q && tick_i) begin
      if (!sclk_q) begin
        // rising edge: capture the incoming bit
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso_i};
      end else begin
        // falling edge: advance the outgoing bit or finish
        sclk_d = 1'b0;
        if (cnt_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 3'd1;
          tx_d  = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign active_o = act_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = tx_q[7];
  assign dout_o   = rx_q;
  assign done_o   = done_q;
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_field_i,
  input  logic              chain_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              byte_load_o,
  output logic [BYTE_W-1:0] byte_out_o,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_in_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o
);
  localparam int RW = LEN_W + 1;

  eng_state_t        st_q, st_d;
  logic [RW-1:0]     rem_q, rem_d;
  logic [WORD_W-1:0] shw_q, shw_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] rxw_q, rxw_d;
  logic [2:0]        nbyte_q, nbyte_d;
  logic              pop_q, pop_d;
  logic              push_q, push_d;
  logic              ovf_q, ovf_d;
  logic              done_q, done_d;

  logic [RW-1:0] burst_bits;
  logic [RW-1:0] eff_rem;
  logic [5:0]    word_bits;
  logic [5:0]    align_amt;

  // length field plus one, rounded up to whole bytes
  assign burst_bits = ({1'b0, len_field_i} + RW'(8)) & ~RW'(7);
  assign eff_rem    = (rem_q == '0) ? burst_bits : rem_q;
  assign word_bits  = (eff_rem[4:0] == 5'd0) ? 6'd32 : {1'b0, eff_rem[4:0]};
  assign align_amt  = 6'd32 - word_bits;

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    shw_d   = shw_q;
    acc_d   = acc_q;
    rxw_d   = rxw_q;
    nbyte_d = nbyte_q;
    pop_d   = 1'b0;
    push_d  = 1'b0;
    ovf_d   = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (tx_empty_i) done_d = 1'b1;
          else            st_d   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        rem_d   = eff_rem;
        shw_d   = tx_data_i << align_amt;
        nbyte_d = word_bits[5:3];
        acc_d   = '0;
        pop_d   = 1'b1;
        st_d    = ST_BYTE_GO;
      end
      ST_BYTE_GO: begin
        st_d = ST_BYTE_WAIT;
      end
      ST_BYTE_WAIT: begin
        if (byte_done_i) begin
          acc_d   = {acc_q[WORD_W-BYTE_W-1:0], byte_in_i};
          rem_d   = rem_q - RW'(8);
          shw_d   = {shw_q[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
          nbyte_d = nbyte_q - 3'd1;
          st_d    = (nbyte_q == 3'd1) ? ST_WORD_END : ST_BYTE_GO;
        end
      end
      ST_WORD_END: begin
        if (rx_full_i) begin
          ovf_d = 1'b1;
        end else begin
          push_d = 1'b1;
          rxw_d  = acc_q;
        end
        if (((rem_q == '0) && !chain_i) || tx_empty_i) done_d = 1'b1;
        st_d = tx_empty_i ? ST_IDLE : ST_LOAD;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      shw_q   <= '0;
      acc_q   <= '0;
      rxw_q   <= '0;
      nbyte_q <= '0;
      pop_q   <= 1'b0;
      push_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      shw_q   <= shw_d;
      acc_q   <= acc_d;
      rxw_q   <= rxw_d;
      nbyte_q <= nbyte_d;
      pop_q   <= pop_d;
      push_q  <= push_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  assign byte_load_o = (st_q == ST_BYTE_GO);
  assign byte_out_o  = shw_q[WORD_W-1 -: BYTE_W];
  assign busy_o      = (st_q != ST_IDLE);
  assign tx_pop_o    = pop_q;
  assign rx_push_o   = push_q;
  assign rx_data_o   = rxw_q;
  assign ovf_o       = ovf_q;
  assign done_o      = done_q;
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_field_i,
  input  logic              chain_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              byte_load;
  logic [BYTE_W-1:0] byte_out;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  logic              shift_active;
  logic              half_tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .len_field_i (len_field_i),
    .chain_i     (chain_i),
    .tx_empty_i  (tx_empty_i),
    .tx_data_i   (tx_data_i),
    .tx_pop_o    (tx_pop_o),
    .rx_full_i   (rx_full_i),
    .rx_data_o   (rx_data_o),
    .rx_push_o   (rx_push_o),
    .byte_load_o (byte_load),
    .byte_out_o  (byte_out),
    .byte_done_i (byte_done),
    .byte_in_i   (byte_in),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o)
  );

  spi_half_timer #(.CLK_HALF(CLK_HALF)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (shift_active),
    .tick_o (half_tick)
  );

  spi_byte_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (byte_load),
    .din_i    (byte_out),
    .tick_i   (half_tick),
    .miso_i   (miso_i),
    .active_o (shift_active),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .dout_o   (byte_in),
    .done_o   (byte_done)
  );
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_pop_o,
  input logic rx_full_i,
  input logic rx_push_o,
  input logic ovf_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o
);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  // R4
  mosi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> !sclk_o);

  // R6
  push_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push_o && ovf_o));

  // R6
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> !$past(rx_full_i));

  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(rx_full_i));

  // R3
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |=> !tx_pop_o);

  // R10
  pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> busy_o);
endmodule

bind spi_burst_engine spi_burst_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_pop_o  (tx_pop_o),
  .rx_full_i (rx_full_i),
  .rx_push_o (rx_push_o),
  .ovf_o     (ovf_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .busy_o    (busy_o)
);

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int HALF       = 2;
  localparam int WATCHDOG   = 150000;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [LEN_W-1:0] field;
  logic             chain;
  logic             tx_empty;
  logic [31:0]      tx_data;
  logic             tx_pop;
  logic             rx_full;
  logic [31:0]      rx_data;
  logic             rx_push;
  logic             sclk;
  logic             mosi;
  logic             miso;
  logic             busy;
  logic             done;
  logic             ovf;

  int checks, errors;
  int cyc;

  logic [31:0] txq [0:15];
  int tx_rd, tx_wr;
  int rx_cap;

  // captured by the monitor
  logic [7:0]  capb [0:63];
  int          ncap;
  logic [31:0] rxw [0:15];
  int          nrx;
  int          pop_cnt, done_cnt, ovf_cnt;
  int          nbit, sbit;
  logic [7:0]  shreg;
  logic        prev_sclk;
  int          rise1, rise2, nrise;

  // expected
  logic [7:0]  eb [0:63];
  int          ne;
  logic [31:0] ew [0:15];
  int          erx, edone, eovf;
  int          mrem;

  assign tx_data  = txq[tx_rd[3:0]];
  assign tx_empty = (tx_rd == tx_wr);
  assign rx_full  = (nrx >= rx_cap);

  spi_burst_engine #(.LEN_W(LEN_W), .CLK_HALF(HALF)) i_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_field_i(field),
    .chain_i(chain), .tx_empty_i(tx_empty), .tx_data_i(tx_data),
    .tx_pop_o(tx_pop), .rx_full_i(rx_full), .rx_data_o(rx_data),
    .rx_push_o(rx_push), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .done_o(done), .ovf_o(ovf)
  );

  function automatic logic [7:0] resp_byte(int k);
    return 8'((k * 29 + 7) & 255);
  endfunction

  function automatic logic resp_bit(int b);
    logic [7:0] v;
    v = resp_byte(b / 8);
    return v[7 - (b % 8)];
  endfunction

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // monitor: slave model and queue models, all at the falling clock edge
  initial begin
    prev_sclk = 1'b0;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (sclk && !prev_sclk) begin
        shreg = {shreg[6:0], mosi};
        nbit++;
        if (nbit % 8 == 0 && ncap < 64) begin
          capb[ncap] = shreg;
          ncap++;
        end
        if (nrise == 0) rise1 = cyc;
        if (nrise == 1) rise2 = cyc;
        nrise++;
        sbit++;
        miso = resp_bit(sbit);
      end
      prev_sclk = sclk;
      if (tx_pop) begin
        tx_rd++;
        pop_cnt++;
      end
      if (rx_push && nrx < 16) begin
        rxw[nrx] = rx_data;
        nrx++;
      end
      if (done) done_cnt++;
      if (ovf)  ovf_cnt++;
    end
  end

  task automatic run_case(input int fld, input bit ch, input int nw,
                          input int cap, input bit restart);
    int b, eff, nbits, k, waitc;
    logic [31:0] w, acc;
    @(posedge clk); #1;
    tx_rd = 0; tx_wr = nw; nrx = 0; rx_cap = cap;
    ncap = 0; pop_cnt = 0; done_cnt = 0; ovf_cnt = 0;
    nbit = 0; sbit = 0; nrise = 0; rise1 = 0; rise2 = 0;
    miso = resp_bit(0);
    field = LEN_W'(fld); chain = ch;
    for (int i = 0; i < nw; i++)
      txq[i] = (32'h9E3779B9 * 32'(i + 1 + fld)) ^ {8'(fld), 24'h0};
    // arithmetic expectation
    b = ((fld + 8) / 8) * 8;
    ne = 0; erx = 0; edone = 0; eovf = 0; k = 0;
    for (int i = 0; i < nw; i++) begin
      w = txq[i];
      eff = (mrem == 0) ? b : mrem;
      nbits = (eff % 32 == 0) ? 32 : eff % 32;
      mrem = eff;
      acc = '0;
      for (int j = 0; j < nbits / 8; j++) begin
        eb[ne] = 8'(w >> (nbits - 8 - 8 * j));
        ne++;
        acc = (acc << 8) | 32'(resp_byte(k));
        k++;
        mrem = mrem - 8;
      end
      if (erx >= cap) eovf++;
      else begin
        ew[erx] = acc;
        erx++;
      end
      if ((mrem == 0 && !ch) || i == nw - 1) edone++;
    end
    if (nw == 0) edone = 1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    waitc = 0;
    do begin
      @(posedge clk); #1;
      waitc++;
      if (restart && waitc == 6) start = 1'b1;
      else start = 1'b0;
    end while (busy && waitc < 5000);
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R10 busy low after drain", longint'(busy), 0);
    chk_eq("R4 sclk idle low", longint'(sclk), 0);
    chk_eq(nw == 0 ? "R9 pops on empty start" : "R3 pop count",
           pop_cnt, nw);
    chk_eq("R3 byte count", ncap, ne);
    for (int i = 0; i < ne && i < ncap; i++)
      chk_eq("R1 R2 R3 mosi byte", capb[i], eb[i]);
    chk_eq("R5 push count", nrx, erx);
    for (int i = 0; i < erx && i < nrx; i++)
      chk_eq("R5 rx word", rxw[i], ew[i]);
    chk_eq("R6 overflow pulses", ovf_cnt, eovf);
    if (nw == 0)      chk_eq("R9 done on empty start", done_cnt, edone);
    else if (ch)      chk_eq("R8 chained done count", done_cnt, edone);
    else              chk_eq("R7 done count", done_cnt, edone);
    if (nrise >= 2)   chk_eq("R4 rise spacing", rise2 - rise1, 2 * HALF);
  endtask

  initial begin
    checks = 0; errors = 0; mrem = 0;
    tx_rd = 0; tx_wr = 0; nrx = 0; rx_cap = 8;
    start = 1'b0; field = '0; chain = 1'b0; miso = 1'b0;
    ncap = 0; nbit = 0; sbit = 0; nrise = 0; shreg = '0;
    pop_cnt = 0; done_cnt = 0; ovf_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R10 reset busy", longint'(busy), 0);
    chk_eq("R10 reset sclk", longint'(sclk), 0);
    chk_eq("R10 reset done", longint'(done), 0);
    chk_eq("R10 reset ovf", longint'(ovf), 0);
    chk_eq("R10 reset pop", longint'(tx_pop), 0);
    chk_eq("R10 reset push", longint'(rx_push), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    run_case(5, 1'b0, 0, 8, 1'b0);
    for (int f = 0; f < 64; f++)
      run_case(f, (f % 3 == 1), 1 + f % 5, (f % 7 == 3) ? 1 : 8, (f % 4 == 2));
    run_case(200, 1'b0, 7, 8, 1'b0);
    run_case(200, 1'b1, 7, 8, 1'b1);
    run_case(39, 1'b0, 6, 2, 1'b0);
    run_case(0, 1'b1, 0, 8, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule